// File: doc/BRIEF.md
# Exception and Interrupt Control Unit

This block keeps the interrupt-related control registers of a small 32-bit processor core and decides, at each instruction boundary, whether an external interrupt is taken. Software reaches the registers through a control-register port used by the register read and write instructions. The port has a combinational read path and a write that takes effect on the next clock edge.

Thirty-two level-sensitive request lines are masked by a per-line enable register. The result is visible as a pending word. When global interrupts are on, some source is pending and the pipeline signals an instruction boundary, the unit does three things in the same cycle. It redirects fetch to a fixed handler vector, asks the register file to save the abandoned instruction's PC plus 4 as the exception address, and drops any control-register write that instruction carried.

An exception-return strobe redirects fetch to the exception address supplied by the register file. It also restores the saved status word. Handler software is expected to subtract 4 from the saved address before returning, so that the interrupted instruction runs again.

Top module: `exc_ctrl_unit`

## Requirements
- R1: After a synchronous active-low reset, control registers 0 (status), 1 (saved status), 2 (debug status) and 3 (interrupt enable) all read 0, and no redirect is requested.
- R2: A write to register index 0, 1, 2 or 3 stores all 32 data bits, and the new value is readable from the next cycle on.
- R3: Index 4 reads the request lines ANDed with the interrupt-enable register. Index 5 reads the constant parameter CPU_ID. Indices 6 and 7 read 0. Writes to indices 4 to 7 change nothing.
- R4: An interrupt is taken in a cycle only when the boundary strobe is 1, status bit 0 is 1 and the pending word is nonzero. Otherwise no interrupt redirect occurs.
- R5: In the cycle an interrupt is taken, redirect_valid is 1, redirect_pc is VECTOR (default 0x20), ea_wr_en is 1 and ea_wr_data is cur_pc plus 4.
- R6: After an interrupt is taken, saved status holds the prior status word, and status equals the prior status with bit 0 cleared.
- R7: On an exception-return strobe with no interrupt taken, redirect_valid is 1 and redirect_pc equals ea_in in that cycle. On the next cycle status equals the prior saved status.
- R8: A control-register write in a cycle where an interrupt is taken is dropped.
- R9: When an interrupt is taken in the same cycle as an exception-return strobe, the interrupt wins: the redirect goes to VECTOR and status is not restored from saved status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_rd_idx | input | 3 | Control register index to read |
| ctl_rd_data | output | 32 | Read data, combinational |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_idx | input | 3 | Control register index to write |
| ctl_wr_data | input | 32 | Write data |
| irq_lines | input | 32 | Level-sensitive interrupt requests |
| cur_pc | input | 32 | PC of the instruction at the boundary |
| insn_boundary | input | 1 | Instruction boundary strobe |
| eret_req | input | 1 | Exception-return strobe |
| ea_in | input | 32 | Current exception-address register value |
| redirect_valid | output | 1 | Fetch redirect request |
| redirect_pc | output | 32 | Redirect target |
| ea_wr_en | output | 1 | Write request for the exception-address register |
| ea_wr_data | output | 32 | Return address to save |

## Verification
On every cycle, the assertions check the cycle-to-cycle state relations: what happens to status after a take, the copy into saved status, the restore after a return, and that a write colliding with a take is lost. They also check that an interrupt redirect always carries the vector and the PC-plus-4 save. The bench scenarios cover the rest. These are the read mux contents for each index, the read-only and unmapped indices, each of the three gating conditions held off in turn, and the precedence of an interrupt over a return in the same cycle, seen through later reads.

// File: rtl/exc_pkg.sv
// Package: shared constants and control-register index type for the
// exception and interrupt control unit.
// Assumes a 3-bit control register index space with six mapped registers.
package exc_pkg;

    localparam int unsigned XLEN  = 32;
    localparam int unsigned IDX_W = 3;

    // Register numbering; decoded by the instruction path, so fixed.
    typedef enum logic [IDX_W-1:0] {
        CTL_STATUS  = 3'd0,
        CTL_ESTAT   = 3'd1,
        CTL_BSTAT   = 3'd2,
        CTL_IEN     = 3'd3,
        CTL_IPEND   = 3'd4,
        CTL_ID      = 3'd5
    } ctl_idx_e;

    // Bit of status that globally enables interrupts.
    localparam int unsigned GIE_BIT = 0;

endpackage

// File: rtl/exc_irq_arbiter.sv
// Module: exc_irq_arbiter
// Masks the raw request lines with the enable register and decides whether
// an interrupt is taken in this cycle. Purely combinational.
// Assumes request lines are already synchronous to clk.
module exc_irq_arbiter #(
    parameter int unsigned NUM_IRQ = 32
) (
    input  logic [NUM_IRQ-1:0] irq_lines,
    input  logic [NUM_IRQ-1:0] irq_enable,
    input  logic               glob_enable,
    input  logic               boundary,
    output logic [NUM_IRQ-1:0] pending,
    output logic               take
);

    // Per-line masking, one gate per source.
    generate
        for (genvar g = 0; g < NUM_IRQ; g++) begin : g_mask
            assign pending[g] = irq_lines[g] & irq_enable[g];
        end
    endgenerate

    // Take decision: boundary, global enable and any pending source.
    always_comb begin
        take = boundary & glob_enable & (|pending);
    end

endmodule

// File: rtl/exc_ctl_regs.sv
// Module: exc_ctl_regs
// Holds status, saved status, debug status and interrupt enable, applies
// take / return / software-write updates, and provides the read mux.
// Assumes take and ret are single-cycle strobes; take has priority over
// ret, and ret over a software write.
module exc_ctl_regs
    import exc_pkg::*;
#(
    parameter int unsigned   W      = 32,
    parameter int unsigned   IW     = 3,
    parameter logic [W-1:0]  CPU_ID = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          ret,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [IW-1:0] rd_idx,
    input  logic [W-1:0]  pending,
    output logic [W-1:0]  rd_data,
    output logic [W-1:0]  ienable,
    output logic          glob_en
);

    logic [W-1:0] status_q, estat_q, bstat_q, ien_q;
    logic         sw_wr;

    // A software write lands only when no take or return overrides it.
    always_comb begin
        sw_wr = wr_en & ~take & ~ret;
    end

    // Status: cleared global enable on take, restored on return, else written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else if (take) begin
            status_q          <= status_q;
            status_q[GIE_BIT] <= 1'b0;
        end else if (ret) begin
            status_q <= estat_q;
        end else if (sw_wr && wr_idx == IW'(CTL_STATUS)) begin
            status_q <= wr_data;
        end
    end

    // Saved status: snapshot on take, else software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            estat_q <= '0;
        end else if (take) begin
            estat_q <= status_q;
        end else if (sw_wr && wr_idx == IW'(CTL_ESTAT)) begin
            estat_q <= wr_data;
        end
    end

    // Debug status and interrupt enable: plain software registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bstat_q <= '0;
            ien_q   <= '0;
        end else if (sw_wr) begin
            if (wr_idx == IW'(CTL_BSTAT)) bstat_q <= wr_data;
            if (wr_idx == IW'(CTL_IEN))   ien_q   <= wr_data;
        end
    end

    // Combinational read mux; unmapped indices read zero.
    always_comb begin
        case (rd_idx)
            IW'(CTL_STATUS): rd_data = status_q;
            IW'(CTL_ESTAT):  rd_data = estat_q;
            IW'(CTL_BSTAT):  rd_data = bstat_q;
            IW'(CTL_IEN):    rd_data = ien_q;
            IW'(CTL_IPEND):  rd_data = pending;
            IW'(CTL_ID):     rd_data = CPU_ID;
            default:         rd_data = '0;
        endcase
    end

    assign ienable = ien_q;
    assign glob_en = status_q[GIE_BIT];

    // R6: global enable is off right after a take.
    p_gie_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !status_q[GIE_BIT]);

    // R6: saved status captures the pre-take status.
    p_estat_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> estat_q == $past(status_q));

    // R7: return without take restores status from saved status.
    p_ret_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && !take) |=> status_q == $past(estat_q));

    // R8: a write to the enable register colliding with a take is lost.
    p_wr_dropped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && wr_en && wr_idx == IW'(CTL_IEN)) |=> ien_q == $past(ien_q));

endmodule

// File: rtl/exc_redirect.sv
// Module: exc_redirect
// Builds the fetch redirect and the exception-address save request.
// Assumes take has priority over ret when both are present.
module exc_redirect #(
    parameter int unsigned  W       = 32,
    parameter logic [W-1:0] VECTOR  = 32'h20,
    parameter logic [W-1:0] PC_STEP = 32'd4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take,
    input  logic         ret,
    input  logic [W-1:0] cur_pc,
    input  logic [W-1:0] ea_in,
    output logic         redirect_valid,
    output logic [W-1:0] redirect_pc,
    output logic         ea_wr_en,
    output logic [W-1:0] ea_wr_data
);

    // Redirect target selection: vector for a take, saved address for a return.
    always_comb begin
        redirect_valid = take | ret;
        redirect_pc    = take ? VECTOR : ea_in;
        ea_wr_en       = take;
        ea_wr_data     = cur_pc + PC_STEP;
    end

    // R5: every save request comes with a redirect to the vector.
    p_take_vector_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ea_wr_en |-> (redirect_valid && redirect_pc == VECTOR));

    // R9: with both strobes present the vector wins.
    p_take_beats_ret_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && ret) |-> redirect_pc == VECTOR);

endmodule

// File: rtl/exc_ctrl_unit.sv
// Module: exc_ctrl_unit (top)
// Exception and interrupt control unit: control registers, interrupt take
// decision and fetch redirect. All outputs except register state are
// combinational on the inputs of the same cycle.
// Assumes the register file performs the exception-address write.
module exc_ctrl_unit #(
    parameter logic [31:0] CPU_ID  = 32'h1234_0001,
    parameter logic [31:0] VECTOR  = 32'h0000_0020,
    parameter logic [31:0] PC_STEP = 32'd4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  ctl_rd_idx,
    output logic [31:0] ctl_rd_data,
    input  logic        ctl_wr_en,
    input  logic [2:0]  ctl_wr_idx,
    input  logic [31:0] ctl_wr_data,
    input  logic [31:0] irq_lines,
    input  logic [31:0] cur_pc,
    input  logic        insn_boundary,
    input  logic        eret_req,
    input  logic [31:0] ea_in,
    output logic        redirect_valid,
    output logic [31:0] redirect_pc,
    output logic        ea_wr_en,
    output logic [31:0] ea_wr_data
);

    localparam int unsigned W  = exc_pkg::XLEN;
    localparam int unsigned IW = exc_pkg::IDX_W;

    logic [W-1:0] ienable, pending;
    logic         glob_en, take;

    exc_irq_arbiter #(.NUM_IRQ(W)) u_arb (
        .irq_lines  (irq_lines),
        .irq_enable (ienable),
        .glob_enable(glob_en),
        .boundary   (insn_boundary),
        .pending    (pending),
        .take       (take)
    );

    exc_ctl_regs #(.W(W), .IW(IW), .CPU_ID(CPU_ID)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take),
        .ret    (eret_req),
        .wr_en  (ctl_wr_en),
        .wr_idx (ctl_wr_idx),
        .wr_data(ctl_wr_data),
        .rd_idx (ctl_rd_idx),
        .pending(pending),
        .rd_data(ctl_rd_data),
        .ienable(ienable),
        .glob_en(glob_en)
    );

    exc_redirect #(.W(W), .VECTOR(VECTOR), .PC_STEP(PC_STEP)) u_redir (
        .clk           (clk),
        .rst_n         (rst_n),
        .take          (take),
        .ret           (eret_req),
        .cur_pc        (cur_pc),
        .ea_in         (ea_in),
        .redirect_valid(redirect_valid),
        .redirect_pc   (redirect_pc),
        .ea_wr_en      (ea_wr_en),
        .ea_wr_data    (ea_wr_data)
    );

    // R4: no take without a boundary strobe.
    p_take_on_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ea_wr_en |-> insn_boundary);

endmodule

// File: tb/tb_exc_ctrl_unit.sv
module tb_exc_ctrl_unit;

    localparam logic [31:0] CPU_ID = 32'h1234_0001;
    localparam logic [31:0] VEC    = 32'h0000_0020;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  ctl_rd_idx;
    logic [31:0] ctl_rd_data;
    logic        ctl_wr_en;
    logic [2:0]  ctl_wr_idx;
    logic [31:0] ctl_wr_data;
    logic [31:0] irq_lines;
    logic [31:0] cur_pc;
    logic        insn_boundary;
    logic        eret_req;
    logic [31:0] ea_in;
    logic        redirect_valid;
    logic [31:0] redirect_pc;
    logic        ea_wr_en;
    logic [31:0] ea_wr_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    exc_ctrl_unit #(.CPU_ID(CPU_ID), .VECTOR(VEC)) dut (
        .clk(clk), .rst_n(rst_n),
        .ctl_rd_idx(ctl_rd_idx), .ctl_rd_data(ctl_rd_data),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_idx(ctl_wr_idx), .ctl_wr_data(ctl_wr_data),
        .irq_lines(irq_lines), .cur_pc(cur_pc), .insn_boundary(insn_boundary),
        .eret_req(eret_req), .ea_in(ea_in),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .ea_wr_en(ea_wr_en), .ea_wr_data(ea_wr_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        ctl_wr_en = 1'b1; ctl_wr_idx = idx; ctl_wr_data = d;
        @(negedge clk);
        ctl_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] d);
        ctl_rd_idx = idx;
        #1;
        d = ctl_rd_data;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int i = 0; i < 4; i++) begin
            rd(3'(i), v);
            chk("R1 reset reg", v, 32'h0);
        end
        chk("R1 no redirect", {31'h0, redirect_valid}, 32'h0);
    endtask

    task automatic t_rw;
        logic [31:0] v;
        wr(3'd1, 32'hA5A5_5A5A);
        wr(3'd2, 32'h0F0F_1234);
        wr(3'd3, 32'hDEAD_BEEF);
        wr(3'd0, 32'h8000_0002);
        rd(3'd1, v); chk("R2 estatus", v, 32'hA5A5_5A5A);
        rd(3'd2, v); chk("R2 bstatus", v, 32'h0F0F_1234);
        rd(3'd3, v); chk("R2 ienable", v, 32'hDEAD_BEEF);
        rd(3'd0, v); chk("R2 status", v, 32'h8000_0002);
        wr(3'd0, 32'h0); wr(3'd1, 32'h0); wr(3'd3, 32'h0);
    endtask

    task automatic t_ro;
        logic [31:0] v;
        wr(3'd3, 32'h0000_00F0);
        irq_lines = 32'h0000_0130;
        rd(3'd4, v); chk("R3 pending", v, 32'h0000_0030);
        wr(3'd4, 32'hFFFF_FFFF);
        wr(3'd5, 32'h0);
        wr(3'd6, 32'hFFFF_FFFF);
        rd(3'd4, v); chk("R3 pending after write", v, 32'h0000_0030);
        rd(3'd5, v); chk("R3 cpuid", v, CPU_ID);
        rd(3'd6, v); chk("R3 idx6", v, 32'h0);
        rd(3'd7, v); chk("R3 idx7", v, 32'h0);
        rd(3'd3, v); chk("R3 ienable untouched", v, 32'h0000_00F0);
        rd(3'd0, v); chk("R3 status untouched", v, 32'h0);
        irq_lines = '0;
        wr(3'd3, 32'h0);
    endtask

    task automatic t_gating;
        wr(3'd3, 32'h0000_0001);
        @(negedge clk);
        irq_lines = 32'h1; insn_boundary = 1'b1; #1;
        chk("R4 off by global enable", {31'h0, redirect_valid}, 32'h0);
        wr(3'd0, 32'h1);
        irq_lines = 32'h2; #1;
        chk("R4 off by empty pending", {31'h0, redirect_valid}, 32'h0);
        irq_lines = 32'h1; insn_boundary = 1'b0; #1;
        chk("R4 off without boundary", {31'h0, redirect_valid}, 32'h0);
        irq_lines = '0;
    endtask

    task automatic t_take;
        logic [31:0] v;
        wr(3'd0, 32'h3);
        @(negedge clk);
        cur_pc = 32'h0000_1000; irq_lines = 32'h1; insn_boundary = 1'b1; #1;
        chk("R4 taken", {31'h0, redirect_valid}, 32'h1);
        chk("R5 vector", redirect_pc, VEC);
        chk("R5 ea write", {31'h0, ea_wr_en}, 32'h1);
        chk("R5 ea data", ea_wr_data, 32'h0000_1004);
        @(negedge clk);
        insn_boundary = 1'b0; irq_lines = '0;
        rd(3'd0, v); chk("R6 status bit0 cleared", v, 32'h2);
        rd(3'd1, v); chk("R6 estatus copy", v, 32'h3);
    endtask

    task automatic t_eret;
        logic [31:0] v;
        @(negedge clk);
        ea_in = 32'h0000_1000; eret_req = 1'b1; #1;
        chk("R7 ret redirect", {31'h0, redirect_valid}, 32'h1);
        chk("R7 ret target", redirect_pc, 32'h0000_1000);
        chk("R7 no ea write", {31'h0, ea_wr_en}, 32'h0);
        @(negedge clk);
        eret_req = 1'b0;
        rd(3'd0, v); chk("R7 status restored", v, 32'h3);
    endtask

    task automatic t_collide;
        logic [31:0] v;
        wr(3'd0, 32'h1);
        @(negedge clk);
        irq_lines = 32'h1; insn_boundary = 1'b1;
        ctl_wr_en = 1'b1; ctl_wr_idx = 3'd3; ctl_wr_data = 32'h0;
        @(negedge clk);
        ctl_wr_en = 1'b0; insn_boundary = 1'b0; irq_lines = '0;
        rd(3'd3, v); chk("R8 write dropped", v, 32'h1);
        rd(3'd0, v); chk("R8 take happened", v, 32'h0);
    endtask

    task automatic t_race;
        logic [31:0] v;
        wr(3'd1, 32'h1);
        wr(3'd0, 32'h1);
        @(negedge clk);
        irq_lines = 32'h1; insn_boundary = 1'b1; eret_req = 1'b1;
        ea_in = 32'h0000_4444; cur_pc = 32'h0000_2000; #1;
        chk("R9 vector wins", redirect_pc, VEC);
        chk("R9 ea data", ea_wr_data, 32'h0000_2004);
        @(negedge clk);
        irq_lines = '0; insn_boundary = 1'b0; eret_req = 1'b0;
        rd(3'd0, v); chk("R9 status not restored", v, 32'h0);
        rd(3'd1, v); chk("R9 estatus from take", v, 32'h1);
    endtask

    initial begin
        rst_n = 1'b0; ctl_rd_idx = '0; ctl_wr_en = 1'b0; ctl_wr_idx = '0;
        ctl_wr_data = '0; irq_lines = '0; cur_pc = '0; insn_boundary = 1'b0;
        eret_req = 1'b0; ea_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset;
        t_rw;
        t_ro;
        t_gating;
        t_take;
        t_eret;
        t_collide;
        t_race;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule